// File: doc/BRIEF.md
# DDR2 Write Command Spacing Gate

This block sits in front of the DRAM command bus and paces the commands that follow a write. A command source offers one command at a time through a valid/ready handshake. The block takes the command into a single hold register and keeps ready low while the command waits. When every spacing rule that applies since the most recent write has been met, the block presents the command on the output strobe for one cycle. Each rule depends on the kind of command that comes next (write, read, precharge/activate) and, for precharge/activate, on whether that command goes to the bank that was written.

The source can mark a write as an interrupt, which asks to cut short the burst that is in progress. The block grants such a request only where an eight-beat burst without auto precharge can be cut at its four-beat midpoint. It refuses every other interrupt request and drops the command, pulses a violation flag, and lets the running burst continue. Burst length, CAS latency, write-to-read delay and write recovery are taken from configuration inputs only while the block is quiet. A change made during a burst therefore applies to the bursts that start after that burst has finished.

Top module: `ddr2_wr_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cmd_ready` is 1 and `out_valid` and `viol` are 0.
- R2: The command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both 1. After acceptance, `cmd_ready` stays 0 until the command issues. The command issues as a one-cycle `out_valid` that carries the same type and bank, no earlier than two cycles after acceptance. Type codes: 0 write, 1 write with auto precharge, 2 read, 3 read with auto precharge, 4 precharge, 5 activate.
- R3: A write (code 0 or 1) that follows a write issues at least BL/2 cycles after it: 2 cycles for BL4 and 4 cycles for BL8. If the write was offered early, it issues exactly at that spacing, so the data stays continuous.
- R4: A read (code 2 or 3) that follows a write issues at least (CL-1) + BL/2 + W cycles after it, and exactly at that point when it was waiting. W is the effective write-to-read delay.
- R5: W is the larger of 2 and `cfg_twtr`. A programmed value of 0 or 1 therefore acts as 2.
- R6: A precharge or activate (code 4 or 5) to the bank of the last write issues at least (CL-1) + BL/2 + `cfg_twr` cycles after that write. The recovery time counts from the end of the data burst.
- R7: A precharge or activate to any other bank, and any command when no write has been issued since reset, needs only a 1-cycle minimum. It therefore issues two cycles after acceptance.
- R8: A write offered with `cmd_intr`=1 and accepted in the cycle where an eight-beat write without auto precharge issues truncates that burst at four beats. It issues 2 cycles after that write.
- R9: Any other interrupt request accepted while the last write's BL/2-cycle window is open is refused. This covers a four-beat burst, a burst with auto precharge, a command other than a write, and an eight-beat burst off its midpoint. On a refusal the command never issues, `viol` is 1 for exactly the cycle after acceptance, and `cmd_ready` stays 1.
- R10: `cfg_bl8` (1 selects BL8), `cfg_cl`, `cfg_twtr` and `cfg_twr` are sampled only while no command is held and no write window is open. Each write uses the values that were sampled when it issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl8 | input | 1 | Burst length select: 1 = eight beats, 0 = four beats |
| cfg_cl | input | CL_W | CAS latency in clocks |
| cfg_twtr | input | TWTR_W | Write-to-read delay in clocks |
| cfg_twr | input | TWR_W | Write recovery time in clocks |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can take a command |
| cmd_type | input | 3 | Command code (see R2) |
| cmd_bank | input | BANK_W | Target bank |
| cmd_intr | input | 1 | Request to cut into the running write burst |
| out_valid | output | 1 | One-cycle issue strobe |
| out_type | output | 3 | Code of the issued command |
| out_bank | output | BANK_W | Bank of the issued command |
| viol | output | 1 | One-cycle pulse on a refused interrupt |

## Verification
Writes are offered back to back in the cycle the previous write issues, once with four-beat and once with eight-beat bursts. The issue spacing then shows whether the gap follows the burst length or only the pipeline. Reads and same-bank precharge/activate are each offered right behind a write with several latency, write-to-read and recovery settings, including write-to-read values below the floor of 2. The resulting exact issue cycles tell the read rule apart from the recovery rule. Interrupt requests are placed at the midpoint of an eight-beat burst, one cycle past it, on a four-beat burst, on a burst with auto precharge, and with a precharge as the interrupting command. This separates the single legal truncation from each refused case. A burst-length change made in the middle of a stream of writes shows when the new setting takes effect.

// File: rtl/ddr2_wr_gate_pkg.sv
package ddr2_wr_gate_pkg;

   typedef enum logic [2:0] {
      CMD_WR   = 3'd0,
      CMD_WRA  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_RDA  = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_ACT  = 3'd5,
      CMD_RSV6 = 3'd6,
      CMD_RSV7 = 3'd7
   } cmd_code_e;

   function automatic logic code_is_write(input logic [2:0] c);
      return (c == CMD_WR) || (c == CMD_WRA);
   endfunction

   function automatic logic code_is_read(input logic [2:0] c);
      return (c == CMD_RD) || (c == CMD_RDA);
   endfunction

   function automatic logic code_is_rowcmd(input logic [2:0] c);
      return (c == CMD_PRE) || (c == CMD_ACT);
   endfunction

endpackage

// File: rtl/wgate_cfg_hold.sv
module wgate_cfg_hold #(
   parameter int CL_W   = 4,
   parameter int TWTR_W = 4,
   parameter int TWR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              in_bl8,
   input  logic [CL_W-1:0]   in_cl,
   input  logic [TWTR_W-1:0] in_twtr,
   input  logic [TWR_W-1:0]  in_twr,
   output logic              cur_bl8,
   output logic [CL_W-1:0]   cur_cl,
   output logic [TWTR_W-1:0] cur_twtr,
   output logic [TWR_W-1:0]  cur_twr
);

   localparam logic [CL_W-1:0]   RST_CL   = CL_W'(3);
   localparam logic [TWTR_W-1:0] RST_TWTR = TWTR_W'(2);
   localparam logic [TWR_W-1:0]  RST_TWR  = TWR_W'(3);

   // Settings change only between bursts, never under a running one.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_bl8  <= 1'b0;
         cur_cl   <= RST_CL;
         cur_twtr <= RST_TWTR;
         cur_twr  <= RST_TWR;
      end else if (upd) begin
         cur_bl8  <= in_bl8;
         cur_cl   <= in_cl;
         cur_twtr <= in_twtr;
         cur_twr  <= in_twr;
      end
   end

endmodule

// File: rtl/wgate_burst_track.sv
module wgate_burst_track #(
   parameter int CL_W   = 4,
   parameter int TWTR_W = 4,
   parameter int TWR_W  = 4,
   parameter int BANK_W = 3,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic              wr_is_ap,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic              cur_bl8,
   input  logic [CL_W-1:0]   cur_cl,
   input  logic [TWTR_W-1:0] cur_twtr,
   input  logic [TWR_W-1:0]  cur_twr,
   output logic              have_wr,
   output logic [CNT_W-1:0]  elapsed,
   output logic              in_window,
   output logic              trunc_ok,
   output logic              l_bl8,
   output logic [CL_W-1:0]   l_cl,
   output logic [TWTR_W-1:0] l_twtr,
   output logic [TWR_W-1:0]  l_twr,
   output logic [BANK_W-1:0] l_bank
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] l_half;

   // elapsed == k in the k-th cycle after the write strobe; saturates.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_wr <= 1'b0;
         elapsed <= '0;
         l_bl8   <= 1'b0;
         l_cl    <= '0;
         l_twtr  <= '0;
         l_twr   <= '0;
         l_bank  <= '0;
      end else if (wr_fire) begin
         have_wr <= 1'b1;
         elapsed <= CNT_W'(1);
         l_bl8   <= cur_bl8;
         l_cl    <= cur_cl;
         l_twtr  <= cur_twtr;
         l_twr   <= cur_twr;
         l_bank  <= wr_bank;
      end else if (elapsed != CNT_MAX) begin
         elapsed <= elapsed + CNT_W'(1);
      end
   end

   assign l_half = l_bl8 ? CNT_W'(4) : CNT_W'(2);

   // The strobe cycle of a write is position 0 of its window.
   assign in_window = wr_fire || (have_wr && (elapsed < l_half));

   // Only the midpoint of an eight-beat burst without auto precharge can be cut.
   assign trunc_ok = wr_fire && cur_bl8 && !wr_is_ap;

endmodule

// File: rtl/wgate_gap_rules.sv
module wgate_gap_rules
   import ddr2_wr_gate_pkg::*;
#(
   parameter int CL_W     = 4,
   parameter int TWTR_W   = 4,
   parameter int TWR_W    = 4,
   parameter int BANK_W   = 3,
   parameter int GW       = 7,
   parameter int TWTR_MIN = 2
) (
   input  logic [2:0]        h_type,
   input  logic [BANK_W-1:0] h_bank,
   input  logic              h_trunc,
   input  logic              l_bl8,
   input  logic [CL_W-1:0]   l_cl,
   input  logic [TWTR_W-1:0] l_twtr,
   input  logic [TWR_W-1:0]  l_twr,
   input  logic [BANK_W-1:0] l_bank,
   output logic [GW-1:0]     min_gap
);

   logic [GW-1:0] half, wlat, wtr, rec;

   always_comb begin
      half = l_bl8 ? GW'(4) : GW'(2);
      wlat = (l_cl == '0) ? '0 : (GW'(l_cl) - GW'(1));
      wtr  = (GW'(l_twtr) < GW'(TWTR_MIN)) ? GW'(TWTR_MIN) : GW'(l_twtr);
      rec  = GW'(l_twr);
      if (h_trunc) begin
         min_gap = GW'(2);
      end else if (code_is_write(h_type)) begin
         min_gap = half;
      end else if (code_is_read(h_type)) begin
         min_gap = wlat + half + wtr;
      end else if (code_is_rowcmd(h_type) && (h_bank == l_bank)) begin
         min_gap = wlat + half + rec;
      end else begin
         min_gap = GW'(1);
      end
   end

endmodule

// File: rtl/ddr2_wr_gate.sv
module ddr2_wr_gate
   import ddr2_wr_gate_pkg::*;
#(
   parameter int CL_W     = 4,
   parameter int TWTR_W   = 4,
   parameter int TWR_W    = 4,
   parameter int BANK_W   = 3,
   parameter int CNT_W    = 6,
   parameter int TWTR_MIN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bl8,
   input  logic [CL_W-1:0]   cfg_cl,
   input  logic [TWTR_W-1:0] cfg_twtr,
   input  logic [TWR_W-1:0]  cfg_twr,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_type,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic              cmd_intr,
   output logic              out_valid,
   output logic [2:0]        out_type,
   output logic [BANK_W-1:0] out_bank,
   output logic              viol
);

   localparam int GW      = CNT_W + 1;
   localparam int TWTR_HI = ((2 ** TWTR_W) - 1 > TWTR_MIN) ? (2 ** TWTR_W) - 1 : TWTR_MIN;
   localparam int RD_WORST  = (2 ** CL_W) - 2 + 4 + TWTR_HI;
   localparam int REC_WORST = (2 ** CL_W) - 2 + 4 + (2 ** TWR_W) - 1;
   localparam int GAP_WORST = (RD_WORST > REC_WORST) ? RD_WORST : REC_WORST;

   generate
      if (CL_W < 2 || TWTR_W < 2 || TWR_W < 2) begin : g_bad_cfg_width
         $fatal(1, "configuration fields need at least 2 bits");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $fatal(1, "bank field needs at least 1 bit");
      end
      if ((2 ** CNT_W) - 1 < GAP_WORST) begin : g_bad_cnt
         $fatal(1, "gap counter too narrow for the largest delay");
      end
   endgenerate

   logic              hold_vld, hold_trunc;
   logic [2:0]        hold_type;
   logic [BANK_W-1:0] hold_bank;

   logic              cur_bl8;
   logic [CL_W-1:0]   cur_cl;
   logic [TWTR_W-1:0] cur_twtr;
   logic [TWR_W-1:0]  cur_twr;

   logic              have_wr, in_window, trunc_ok, l_bl8;
   logic [CNT_W-1:0]  elapsed;
   logic [CL_W-1:0]   l_cl;
   logic [TWTR_W-1:0] l_twtr;
   logic [TWR_W-1:0]  l_twr;
   logic [BANK_W-1:0] l_bank;
   logic [GW-1:0]     min_gap, gap_next;

   logic wr_fire, accept, refuse, take_trunc, go;

   wgate_cfg_hold #(.CL_W(CL_W), .TWTR_W(TWTR_W), .TWR_W(TWR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .upd(!hold_vld && !in_window),
      .in_bl8(cfg_bl8), .in_cl(cfg_cl), .in_twtr(cfg_twtr), .in_twr(cfg_twr),
      .cur_bl8(cur_bl8), .cur_cl(cur_cl), .cur_twtr(cur_twtr), .cur_twr(cur_twr)
   );

   assign wr_fire = out_valid && code_is_write(out_type);

   wgate_burst_track #(.CL_W(CL_W), .TWTR_W(TWTR_W), .TWR_W(TWR_W),
                       .BANK_W(BANK_W), .CNT_W(CNT_W)) u_track (
      .clk(clk), .rst_n(rst_n),
      .wr_fire(wr_fire), .wr_is_ap(out_type == CMD_WRA), .wr_bank(out_bank),
      .cur_bl8(cur_bl8), .cur_cl(cur_cl), .cur_twtr(cur_twtr), .cur_twr(cur_twr),
      .have_wr(have_wr), .elapsed(elapsed), .in_window(in_window), .trunc_ok(trunc_ok),
      .l_bl8(l_bl8), .l_cl(l_cl), .l_twtr(l_twtr), .l_twr(l_twr), .l_bank(l_bank)
   );

   wgate_gap_rules #(.CL_W(CL_W), .TWTR_W(TWTR_W), .TWR_W(TWR_W), .BANK_W(BANK_W),
                     .GW(GW), .TWTR_MIN(TWTR_MIN)) u_rules (
      .h_type(hold_type), .h_bank(hold_bank), .h_trunc(hold_trunc),
      .l_bl8(l_bl8), .l_cl(l_cl), .l_twtr(l_twtr), .l_twr(l_twr), .l_bank(l_bank),
      .min_gap(min_gap)
   );

   assign cmd_ready  = !hold_vld;
   assign accept     = cmd_valid && !hold_vld;
   assign refuse     = accept && cmd_intr && in_window &&
                       !(trunc_ok && code_is_write(cmd_type));
   assign take_trunc = accept && cmd_intr && in_window && !refuse;

   // Gap the held command would have if it issued in the next cycle.
   assign gap_next = {1'b0, elapsed} + GW'(1);
   assign go       = hold_vld && (!have_wr || (gap_next >= min_gap));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_vld   <= 1'b0;
         hold_trunc <= 1'b0;
         hold_type  <= '0;
         hold_bank  <= '0;
         out_valid  <= 1'b0;
         out_type   <= '0;
         out_bank   <= '0;
         viol       <= 1'b0;
      end else begin
         out_valid <= go;
         viol      <= refuse;
         if (go) begin
            out_type <= hold_type;
            out_bank <= hold_bank;
            hold_vld <= 1'b0;
         end else if (accept && !refuse) begin
            hold_vld   <= 1'b1;
            hold_type  <= cmd_type;
            hold_bank  <= cmd_bank;
            hold_trunc <= take_trunc;
         end
      end
   end

endmodule

// File: rtl/wgate_chk.sv
module wgate_chk
   import ddr2_wr_gate_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_ready,
   input logic       out_valid,
   input logic [2:0] out_type,
   input logic       viol
);

   logic [7:0] since_wr;
   logic       seen_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_wr <= '0;
         seen_wr  <= 1'b0;
      end else if (out_valid && code_is_write(out_type)) begin
         since_wr <= 8'd1;
         seen_wr  <= 1'b1;
      end else if (since_wr != 8'hFF) begin
         since_wr <= since_wr + 8'd1;
      end
   end

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R2

   AST_STALL_BEFORE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$past(cmd_ready)); // R2

   AST_WR_GAP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen_wr && code_is_write(out_type)) |-> (since_wr >= 8'd2)); // R3

   AST_RD_GAP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen_wr && code_is_read(out_type)) |-> (since_wr >= 8'd4)); // R4

   AST_VIOL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> !out_valid); // R9

   AST_VIOL_READY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> cmd_ready); // R9

endmodule

bind ddr2_wr_gate wgate_chk u_wgate_chk (
   .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
   .out_valid(out_valid), .out_type(out_type), .viol(viol)
);

// File: tb/ddr2_wr_gate_tb_top.sv
`timescale 1ns/1ps
module ddr2_wr_gate_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_bl8 = 1'b0;
   logic [3:0] cfg_cl = 4'd4, cfg_twtr = 4'd3, cfg_twr = 4'd5;
   logic       cmd_valid = 1'b0, cmd_intr = 1'b0;
   logic [2:0] cmd_type = '0, cmd_bank = '0;
   logic       cmd_ready, out_valid, viol;
   logic [2:0] out_type, out_bank;

   always #2 clk = ~clk;

   ddr2_wr_gate dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_bl8(cfg_bl8), .cfg_cl(cfg_cl),
      .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
      .cmd_intr(cmd_intr), .out_valid(out_valid), .out_type(out_type),
      .out_bank(out_bank), .viol(viol)
   );

   typedef struct {
      bit         is_viol;
      logic [2:0] ctype;
      logic [2:0] bank;
      int         at;
      string      req;
   } exp_t;

   exp_t sbq[$];
   int   cyc = 0;
   int   n_chk = 0, n_err = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on each strobe or violation pulse.
   always @(negedge clk) begin
      if (rst_n && !done && (out_valid || viol)) begin
         if (sbq.size() == 0) begin
            check(0, "R2", out_valid ? "unexpected strobe cycle" : "unexpected viol cycle",
                  cyc, -1);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            check(viol == e.is_viol, e.req, "event kind (1=viol)", int'(viol), int'(e.is_viol));
            check(cyc == e.at, e.req, "event cycle", cyc, e.at);
            if (!e.is_viol) begin
               check(out_type == e.ctype, e.req, "issued type", int'(out_type), int'(e.ctype));
               check(out_bank == e.bank, e.req, "issued bank", int'(out_bank), int'(e.bank));
            end
         end
      end
   end

   task automatic send(input logic [2:0] t, input logic [2:0] b, input bit intr,
                       input int at, output int acc);
      @(negedge clk);
      while (cyc < at) @(negedge clk);
      cmd_type = t; cmd_bank = b; cmd_intr = intr; cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      acc = cyc;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0; cmd_intr = 1'b0;
   endtask

   task automatic exp_out(input logic [2:0] t, input logic [2:0] b, input int at,
                          input string req);
      exp_t e;
      e.is_viol = 0; e.ctype = t; e.bank = b; e.at = at; e.req = req;
      sbq.push_back(e);
   endtask

   task automatic exp_viol(input int at, input string req);
      exp_t e;
      e.is_viol = 1; e.ctype = '0; e.bank = '0; e.at = at; e.req = req;
      sbq.push_back(e);
   endtask

   task automatic set_cfg(input bit bl8, input int cl, input int twtr, input int twr);
      repeat (40) @(negedge clk);
      cfg_bl8 = bl8; cfg_cl = 4'(cl); cfg_twtr = 4'(twtr); cfg_twr = 4'(twr);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      check(0, "WD", "watchdog expired, cycle", cyc, 0);
      finish_run();
   end

   initial begin
      int a, a2, t1, t2, t4;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(cmd_ready == 1'b1, "R1", "ready in reset", int'(cmd_ready), 1);
      check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      check(viol == 1'b0, "R1", "viol in reset", int'(viol), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b1 && !out_valid && !viol, "R1", "state after reset", 0, 0);

      // R2 / R7: no prior write, earliest slot
      send(3'd5, 3'd1, 0, 0, a);
      check(cmd_ready == 1'b0, "R2", "ready low while held", int'(cmd_ready), 0);
      exp_out(3'd5, 3'd1, a + 2, "R2");

      // R3: BL4 writes back to back -> gap 2
      set_cfg(0, 4, 3, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R3");
      send(3'd1, 3'd0, 0, t1, a2); exp_out(3'd1, 3'd0, t1 + 2, "R3");

      // R3: BL8 writes back to back -> gap 4
      set_cfg(1, 4, 3, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R3");
      send(3'd0, 3'd2, 0, t1, a2); exp_out(3'd0, 3'd2, t1 + 4, "R3");

      // R8: legal truncation at the midpoint of BL8
      set_cfg(1, 4, 3, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R8");
      send(3'd0, 3'd3, 1, t1, a2); exp_out(3'd0, 3'd3, t1 + 2, "R8");

      // R9: BL8 interrupt one cycle past the midpoint slot
      set_cfg(1, 4, 3, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R9");
      send(3'd0, 3'd0, 1, t1 + 1, a2); exp_viol(t1 + 2, "R9");
      check(cmd_ready == 1'b1, "R9", "ready after refusal", int'(cmd_ready), 1);

      // R9: burst with auto precharge cannot be cut
      set_cfg(1, 4, 3, 5);
      send(3'd1, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd1, 3'd0, t1, "R9");
      send(3'd0, 3'd1, 1, t1, a2); exp_viol(t1 + 1, "R9");

      // R9: non-write interrupt of BL8
      set_cfg(1, 4, 3, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R9");
      send(3'd4, 3'd5, 1, t1, a2); exp_viol(t1 + 1, "R9");

      // R9: BL4 cannot be interrupted
      set_cfg(0, 4, 3, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R9");
      send(3'd0, 3'd0, 1, t1, a2); exp_viol(t1 + 1, "R9");

      // R4: read after BL4 write, CL4 tWTR3 -> 3+2+3 = 8
      set_cfg(0, 4, 3, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R4");
      send(3'd2, 3'd0, 0, t1, a2); exp_out(3'd2, 3'd0, t1 + 8, "R4");

      // R5: tWTR 1 floors to 2 -> 3+2+2 = 7
      set_cfg(0, 4, 1, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R5");
      send(3'd3, 3'd4, 0, t1, a2); exp_out(3'd3, 3'd4, t1 + 7, "R5");

      // R5: tWTR 0 floors to 2, BL8 CL3 -> 2+4+2 = 8
      set_cfg(1, 3, 0, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R5");
      send(3'd2, 3'd0, 0, t1, a2); exp_out(3'd2, 3'd0, t1 + 8, "R5");

      // R6: same-bank precharge, BL4 CL4 tWR5 -> 3+2+5 = 10
      set_cfg(0, 4, 3, 5);
      send(3'd0, 3'd2, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd2, t1, "R6");
      send(3'd4, 3'd2, 0, t1, a2); exp_out(3'd4, 3'd2, t1 + 10, "R6");

      // R6: same-bank activate, BL8 CL3 tWR2 -> 2+4+2 = 8
      set_cfg(1, 3, 3, 2);
      send(3'd1, 3'd6, 0, 0, a); t1 = a + 2; exp_out(3'd1, 3'd6, t1, "R6");
      send(3'd5, 3'd6, 0, t1, a2); exp_out(3'd5, 3'd6, t1 + 8, "R6");

      // R7: other-bank precharge after auto-precharge write
      set_cfg(0, 4, 3, 5);
      send(3'd1, 3'd2, 0, 0, a); t1 = a + 2; exp_out(3'd1, 3'd2, t1, "R7");
      send(3'd4, 3'd3, 0, t1, a2); exp_out(3'd4, 3'd3, t1 + 2, "R7");

      // R10: burst length change during a write stream applies afterwards
      set_cfg(0, 4, 3, 5);
      send(3'd0, 3'd0, 0, 0, a); t1 = a + 2; exp_out(3'd0, 3'd0, t1, "R10");
      @(negedge clk);
      cfg_bl8 = 1'b1;
      send(3'd0, 3'd1, 0, t1, a2); t2 = t1 + 2; exp_out(3'd0, 3'd1, t2, "R10");
      send(3'd0, 3'd2, 0, t2, a2); exp_out(3'd0, 3'd2, t2 + 2, "R10");
      repeat (20) @(negedge clk);
      send(3'd0, 3'd3, 0, 0, a); t4 = a + 2; exp_out(3'd0, 3'd3, t4, "R10");
      send(3'd0, 3'd4, 0, t4, a2); exp_out(3'd0, 3'd4, t4 + 4, "R10");

      repeat (30) @(negedge clk);
      check(sbq.size() == 0, "R2", "events still pending", sbq.size(), 0);
      finish_run();
   end

endmodule